// File: doc/BRIEF.md
# Packet-Scoped Vector Register Forwarding

This block is a small vector register file whose writes take effect per execution packet rather than per cycle. Inside a packet, readers see the register contents from the start of the packet. There is one exception: a register that is the target of the packet's load. Readers of that register see the load result. The load is guarded by a predicate and carries a kind. A temporary load is seen only by readers inside the packet and is dropped at commit. A current load is also written back at commit.

The load reaches the block over a valid/ready port and is held in a staging buffer. The staging buffer is first loaded with the target register's pre-packet contents. The load data replaces that copy only when the predicate is true, so a false predicate forwards the old value with no special read path. Vector ALU results arrive on plain write lanes, plus one register-pair lane, and are sampled on the single-cycle commit strobe. The commit strobe ends the packet. It updates the architectural registers and empties the staging buffer.

The load port follows these back-pressure rules. `ld_ready` is high only when no load is staged and `commit` is low, so each packet accepts at most one load. A load is taken on a clock edge where `ld_valid` and `ld_ready` are both high. A load offered while `ld_ready` is low is not taken and has no effect. The commit, read and ALU pins carry no handshake.

Top module: `vpf_regfile`

## Requirements
- R1: After reset every register holds zero, `ld_ready` is high and every read port returns zero.
- R2: After a temporary load (`ld_kind`=0) with a true predicate is accepted, reads of its target register return the load data until commit. Reads of every other register return their pre-packet values.
- R3: At commit, a temporary load leaves its target register unchanged.
- R4: A current load (`ld_kind`=1) with a true predicate is forwarded like R2. At commit its data is written to the target register.
- R5: When the load predicate is false, reads of the target register within the packet return its pre-packet value, whatever the load kind.
- R6: At commit, a current load with a false predicate leaves its target register unchanged.
- R7: `ld_ready` is low while a load is staged and during the commit cycle. A load offered while `ld_ready` is low changes neither the read values nor the committed state.
- R8: ALU lane writes (`alu_we[i]`, `alu_reg`/`alu_data` slice i) take effect only on a commit cycle. They are never visible to in-packet reads, and asserting them without commit has no effect.
- R9: A pair write puts `pair_data[VW-1:0]` into the even register `{pair_reg[RW-1:1],0}` and `pair_data[2VW-1:VW]` into the odd register after it. Bit 0 of `pair_reg` is ignored.
- R10: When several commit sources target one register, the priority is: a current load with a true predicate first, then ALU lanes with the higher lane index winning, then the pair write.
- R11: Commit empties the staging buffer. In the next cycle reads return the newly committed contents, and `ld_ready` is high if `commit` has dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load offered |
| ld_ready | output | 1 | Load can be taken this cycle |
| ld_reg | input | RW | Load target register |
| ld_kind | input | 1 | 0 temporary, 1 current |
| ld_pred | input | 1 | Load predicate |
| ld_data | input | VW | Load data |
| rd_reg | input | NRD*RW | Read port register indices, port i in slice i |
| rd_data | output | NRD*VW | In-packet read values, port i in slice i |
| commit | input | 1 | Single-cycle packet commit strobe |
| alu_we | input | NWR | ALU lane write enables |
| alu_reg | input | NWR*RW | ALU lane targets |
| alu_data | input | NWR*VW | ALU lane data |
| pair_we | input | 1 | Pair write enable |
| pair_reg | input | RW | Pair target, bit 0 ignored |
| pair_data | input | 2*VW | Pair data, low half to the even register |
| arch_state | output | NREG*VW | Committed registers, register i in slice i |

## Verification
The bench builds the block with 8-bit registers, four registers, two read ports and two ALU lanes. This is narrow enough to sweep every target register against both load kinds and both predicate values, with fresh register contents seeded through the commit path each time. Two lanes plus a pair write over four registers reach every overlap that the R10 priority must resolve. The set includes the case where `pair_reg` has bit 0 set. A second load offered into a busy packet is checked to be ignored. The small width keeps every expected value easy to compute in the bench.

// File: rtl/vpf_pkg.sv
`timescale 1ns/1ps
package vpf_pkg;
  typedef enum logic {
    LD_TEMP = 1'b0,
    LD_CUR  = 1'b1
  } ld_kind_e;

  typedef struct packed {
    logic vld;
    logic keep;
  } stage_flags_t;
endpackage

// File: rtl/vpf_stage.sv
`timescale 1ns/1ps
module vpf_stage
  import vpf_pkg::*;
#(
  parameter int VW   = 1024,
  parameter int NREG = 8,
  parameter int RW   = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 commit,
  input  logic [RW-1:0]        ld_reg,
  input  ld_kind_e             ld_kind,
  input  logic                 ld_pred,
  input  logic [VW-1:0]        ld_data,
  input  logic [NREG*VW-1:0]   arch_flat,
  output stage_flags_t         stg_flags,
  output logic [RW-1:0]        stg_reg,
  output logic [VW-1:0]        stg_data
);
  logic [VW-1:0] preload_w;
  logic [VW-1:0] fill_w;

  // Staging word starts as the pre-packet contents; load data overrides it
  // only under a true predicate.
  always_comb begin
    preload_w = arch_flat[ld_reg*VW +: VW];
    fill_w    = preload_w;
    if (ld_pred) fill_w = ld_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_flags <= '0;
      stg_reg   <= '0;
      stg_data  <= '0;
    end else if (commit) begin
      stg_flags <= '0;
      stg_data  <= '0;
    end else if (accept) begin
      stg_flags.vld  <= 1'b1;
      stg_flags.keep <= (ld_kind == LD_CUR) && ld_pred;
      stg_reg        <= ld_reg;
      stg_data       <= fill_w;
    end
  end
endmodule

// File: rtl/vpf_fwd.sv
`timescale 1ns/1ps
module vpf_fwd
  import vpf_pkg::*;
#(
  parameter int VW   = 1024,
  parameter int NREG = 8,
  parameter int NRD  = 2,
  parameter int RW   = $clog2(NREG)
) (
  input  logic [NREG*VW-1:0] arch_flat,
  input  stage_flags_t       stg_flags,
  input  logic [RW-1:0]      stg_reg,
  input  logic [VW-1:0]      stg_data,
  input  logic [NRD*RW-1:0]  rd_reg,
  output logic [NRD*VW-1:0]  rd_data
);
  for (genvar p = 0; p < NRD; p++) begin : g_port
    logic [RW-1:0] sel_w;
    logic          hit_w;
    assign sel_w = rd_reg[p*RW +: RW];
    assign hit_w = stg_flags.vld && (stg_reg == sel_w);
    assign rd_data[p*VW +: VW] = hit_w ? stg_data : arch_flat[sel_w*VW +: VW];
  end
endmodule

// File: rtl/vpf_arch.sv
`timescale 1ns/1ps
module vpf_arch
  import vpf_pkg::*;
#(
  parameter int VW   = 1024,
  parameter int NREG = 8,
  parameter int NWR  = 2,
  parameter int RW   = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit,
  input  logic [NWR-1:0]      alu_we,
  input  logic [NWR*RW-1:0]   alu_reg,
  input  logic [NWR*VW-1:0]   alu_data,
  input  logic                pair_we,
  input  logic [RW-1:0]       pair_reg,
  input  logic [2*VW-1:0]     pair_data,
  input  stage_flags_t        stg_flags,
  input  logic [RW-1:0]       stg_reg,
  input  logic [VW-1:0]       stg_data,
  output logic [NREG*VW-1:0]  arch_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [RW-1:0] IDX = RW'(g);
    logic [VW-1:0] q_r;
    logic [VW-1:0] nxt_w;

    // Lowest priority first: pair, then lanes by index, then kept load.
    always_comb begin
      nxt_w = q_r;
      if (pair_we && (pair_reg[RW-1:1] == IDX[RW-1:1]))
        nxt_w = pair_data[IDX[0]*VW +: VW];
      for (int l = 0; l < NWR; l++) begin
        if (alu_we[l] && (alu_reg[l*RW +: RW] == IDX))
          nxt_w = alu_data[l*VW +: VW];
      end
      if (stg_flags.vld && stg_flags.keep && (stg_reg == IDX))
        nxt_w = stg_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)      q_r <= '0;
      else if (commit) q_r <= nxt_w;
    end

    assign arch_flat[g*VW +: VW] = q_r;
  end
endmodule

// File: rtl/vpf_regfile.sv
`timescale 1ns/1ps
module vpf_regfile
  import vpf_pkg::*;
#(
  parameter int VW   = 1024,
  parameter int NREG = 8,
  parameter int NRD  = 2,
  parameter int NWR  = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_valid,
  output logic                ld_ready,
  input  logic [RW-1:0]       ld_reg,
  input  logic                ld_kind,
  input  logic                ld_pred,
  input  logic [VW-1:0]       ld_data,
  input  logic [NRD*RW-1:0]   rd_reg,
  output logic [NRD*VW-1:0]   rd_data,
  input  logic                commit,
  input  logic [NWR-1:0]      alu_we,
  input  logic [NWR*RW-1:0]   alu_reg,
  input  logic [NWR*VW-1:0]   alu_data,
  input  logic                pair_we,
  input  logic [RW-1:0]       pair_reg,
  input  logic [2*VW-1:0]     pair_data,
  output logic [NREG*VW-1:0]  arch_state
);
  stage_flags_t  stg_flags;
  logic [RW-1:0] stg_reg;
  logic [VW-1:0] stg_data;
  logic          accept;
  ld_kind_e      kind_w;

  assign ld_ready = !stg_flags.vld && !commit;
  assign accept   = ld_valid && ld_ready;
  assign kind_w   = ld_kind_e'(ld_kind);

  vpf_stage #(.VW(VW), .NREG(NREG), .RW(RW)) i_stage (
    .clk(clk), .rst_n(rst_n), .accept(accept), .commit(commit),
    .ld_reg(ld_reg), .ld_kind(kind_w), .ld_pred(ld_pred), .ld_data(ld_data),
    .arch_flat(arch_state), .stg_flags(stg_flags), .stg_reg(stg_reg),
    .stg_data(stg_data)
  );

  vpf_fwd #(.VW(VW), .NREG(NREG), .NRD(NRD), .RW(RW)) i_fwd (
    .arch_flat(arch_state), .stg_flags(stg_flags), .stg_reg(stg_reg),
    .stg_data(stg_data), .rd_reg(rd_reg), .rd_data(rd_data)
  );

  vpf_arch #(.VW(VW), .NREG(NREG), .NWR(NWR), .RW(RW)) i_arch (
    .clk(clk), .rst_n(rst_n), .commit(commit), .alu_we(alu_we),
    .alu_reg(alu_reg), .alu_data(alu_data), .pair_we(pair_we),
    .pair_reg(pair_reg), .pair_data(pair_data), .stg_flags(stg_flags),
    .stg_reg(stg_reg), .stg_data(stg_data), .arch_flat(arch_state)
  );
endmodule

// File: rtl/vpf_regfile_chk.sv
`timescale 1ns/1ps
module vpf_regfile_chk #(
  parameter int VW   = 1024,
  parameter int NREG = 8,
  parameter int NWR  = 2,
  parameter int RW   = $clog2(NREG)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ld_valid,
  input logic               ld_ready,
  input logic [RW-1:0]      ld_reg,
  input logic               ld_kind,
  input logic               ld_pred,
  input logic [VW-1:0]      ld_data,
  input logic [RW-1:0]      rd_reg0,
  input logic [VW-1:0]      rd_data0,
  input logic               commit,
  input logic [NWR-1:0]     alu_we,
  input logic               pair_we,
  input logic [NREG*VW-1:0] arch_state
);
  function automatic logic [VW-1:0] word_of(input logic [NREG*VW-1:0] s,
                                            input logic [RW-1:0] i);
    return s[i*VW +: VW];
  endfunction

  logic          acc_w, idle_w;
  logic          p_vld, p_cur, p_pred;
  logic [RW-1:0] p_reg;
  logic [VW-1:0] p_data, p_pre;

  assign acc_w  = ld_valid && ld_ready;
  assign idle_w = (alu_we == '0) && !pair_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_vld <= 1'b0; p_cur <= 1'b0; p_pred <= 1'b0;
      p_reg <= '0; p_data <= '0; p_pre <= '0;
    end else if (commit) begin
      p_vld <= 1'b0;
    end else if (acc_w) begin
      p_vld  <= 1'b1;
      p_cur  <= ld_kind;
      p_pred <= ld_pred;
      p_reg  <= ld_reg;
      p_data <= ld_data;
      p_pre  <= word_of(arch_state, ld_reg);
    end
  end

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w |=> !ld_ready); // R7
  AST_FWD_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (p_vld && p_pred && rd_reg0 == p_reg) |-> rd_data0 == p_data); // R2
  AST_FWD_PREPACKET: assert property (@(posedge clk) disable iff (!rst_n)
    (p_vld && !p_pred && rd_reg0 == p_reg) |-> rd_data0 == p_pre); // R5
  AST_TEMP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && p_vld && !p_cur && idle_w) |=> $stable(arch_state)); // R3
  AST_CUR_FALSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && p_vld && p_cur && !p_pred && idle_w) |=> $stable(arch_state)); // R6
  AST_CUR_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && p_vld && p_cur && p_pred && idle_w)
      |=> word_of(arch_state, $past(p_reg)) == $past(p_data)); // R4
  AST_STAGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (ld_ready || commit)); // R11
endmodule

bind vpf_regfile vpf_regfile_chk #(.VW(VW), .NREG(NREG), .NWR(NWR), .RW(RW)) i_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .ld_reg(ld_reg), .ld_kind(ld_kind), .ld_pred(ld_pred), .ld_data(ld_data),
  .rd_reg0(rd_reg[RW-1:0]), .rd_data0(rd_data[VW-1:0]), .commit(commit),
  .alu_we(alu_we), .pair_we(pair_we), .arch_state(arch_state)
);

// File: tb/test_vpf_regfile.sv
`timescale 1ns/1ps
module test_vpf_regfile;
  localparam int VW = 8, NREG = 4, NRD = 2, NWR = 2, RW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 0, ld_kind = 0, ld_pred = 0, commit = 0, pair_we = 0;
  logic ld_ready;
  logic [RW-1:0] ld_reg = '0, pair_reg = '0;
  logic [VW-1:0] ld_data = '0;
  logic [NRD*RW-1:0] rd_reg = '0;
  logic [NRD*VW-1:0] rd_data;
  logic [NWR-1:0] alu_we = '0;
  logic [NWR*RW-1:0] alu_reg = '0;
  logic [NWR*VW-1:0] alu_data = '0;
  logic [2*VW-1:0] pair_data = '0;
  logic [NREG*VW-1:0] arch_state;

  int nchk = 0, nerr = 0;
  logic [VW-1:0] m [NREG];
  logic          s_keep;
  logic [RW-1:0] s_reg;
  logic [VW-1:0] s_data;

  always #4 clk = ~clk;

  vpf_regfile #(.VW(VW), .NREG(NREG), .NRD(NRD), .NWR(NWR)) i_vpf_regfile (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_reg(ld_reg), .ld_kind(ld_kind), .ld_pred(ld_pred), .ld_data(ld_data),
    .rd_reg(rd_reg), .rd_data(rd_data), .commit(commit), .alu_we(alu_we),
    .alu_reg(alu_reg), .alu_data(alu_data), .pair_we(pair_we),
    .pair_reg(pair_reg), .pair_data(pair_data), .arch_state(arch_state)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_arch(input string req);
    for (int i = 0; i < NREG; i++) chk(req, 32'(arch_state[i*VW +: VW]), 32'(m[i]));
  endtask

  task automatic rd2(input logic [RW-1:0] a, input logic [RW-1:0] b);
    rd_reg = {b, a};
    #1;
  endtask

  // Commit with ALU sources; the model applies R10 priority.
  task automatic do_commit(input logic [1:0] we, input logic [RW-1:0] r0, input logic [VW-1:0] d0,
                           input logic [RW-1:0] r1, input logic [VW-1:0] d1,
                           input logic pw, input logic [RW-1:0] pr, input logic [2*VW-1:0] pd);
    @(negedge clk);
    alu_we = we; alu_reg = {r1, r0}; alu_data = {d1, d0};
    pair_we = pw; pair_reg = pr; pair_data = pd; commit = 1'b1;
    #1 chk("R7 ready low at commit", 32'(ld_ready), 0);
    if (pw) begin
      m[{pr[1], 1'b0}] = pd[VW-1:0];
      m[{pr[1], 1'b1}] = pd[2*VW-1:VW];
    end
    if (we[0]) m[r0] = d0;
    if (we[1]) m[r1] = d1;
    if (s_keep) m[s_reg] = s_data;
    s_keep = 1'b0;
    @(negedge clk);
    commit = 1'b0; alu_we = '0; pair_we = 1'b0;
    #1;
  endtask

  task automatic do_load(input logic [RW-1:0] r, input logic k, input logic p, input logic [VW-1:0] d);
    @(negedge clk);
    chk("R7 ready high in empty packet", 32'(ld_ready), 1);
    ld_valid = 1; ld_reg = r; ld_kind = k; ld_pred = p; ld_data = d;
    @(negedge clk);
    ld_valid = 0;
    s_keep = k && p; s_reg = r; s_data = p ? d : m[r];
  endtask

  task automatic seed(input logic [VW-1:0] base);
    do_commit(2'b11, 2'd2, VW'(base + 8'd58), 2'd3, VW'(base + 8'd87),
              1'b1, 2'd0, {VW'(base + 8'd29), base});
  endtask

  initial begin
    #1_600_000;
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    s_keep = 0; s_reg = '0; s_data = '0;
    for (int i = 0; i < NREG; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset ready", 32'(ld_ready), 1);
    chk_arch("R1 reset state");
    rd2(2'd1, 2'd3);
    chk("R1 reset read", 32'(rd_data), 0);

    for (int r = 0; r < NREG; r++)
      for (int k = 0; k < 2; k++)
        for (int p = 0; p < 2; p++) begin
          logic [VW-1:0] base, d, junk;
          logic [RW-1:0] o;
          base = VW'(r * 16 + k * 4 + p * 2 + 3);
          o = RW'(r + 1);
          seed(base);
          chk_arch("R9 R8 seed commit");
          // lanes without commit: no effect
          @(negedge clk);
          alu_we = 2'b11; alu_reg = {o, RW'(r)}; alu_data = {~base, ~base};
          @(negedge clk);
          alu_we = '0;
          #1 chk_arch("R8 lanes ignored without commit");
          d = m[r] ^ 8'hA5;
          do_load(RW'(r), k[0], p[0], d);
          chk("R7 ready low while staged", 32'(ld_ready), 0);
          // second load into a busy packet is not taken
          junk = m[o] ^ 8'h3C;
          ld_valid = 1; ld_reg = o; ld_kind = 1; ld_pred = 1; ld_data = junk;
          @(negedge clk);
          ld_valid = 0;
          rd2(RW'(r), o);
          chk(p ? (k ? "R4 forward current" : "R2 forward temporary") : "R5 false predicate pre-packet",
              32'(rd_data[VW-1:0]), 32'(p ? d : m[r]));
          chk("R7 R2 other register untouched", 32'(rd_data[2*VW-1:VW]), 32'(m[o]));
          // ALU lane on commit not seen in packet before commit (R8)
          @(negedge clk);
          alu_we = 2'b01; alu_reg = {RW'(0), o}; alu_data = {8'h00, junk};
          #1 chk("R8 lane not forwarded", 32'(rd_data[2*VW-1:VW]), 32'(m[o]));
          alu_we = '0;
          do_commit(2'b00, 2'd0, 8'h0, 2'd0, 8'h0, 1'b0, 2'd0, 16'h0);
          chk((k && p) ? "R4 current committed" : (k ? "R6 false current unchanged" : "R3 temporary dropped"),
              32'(arch_state[r*VW +: VW]), 32'(m[r]));
          chk_arch("R3 R4 R6 full state");
          chk("R11 ready after commit", 32'(ld_ready), 1);
          rd2(RW'(r), o);
          chk("R11 read after commit", 32'(rd_data[VW-1:0]), 32'(m[r]));
        end

    // Priority: current load beats lanes and pair; pair LSB ignored
    seed(8'h11);
    do_load(2'd2, 1'b1, 1'b1, 8'hE7);
    do_commit(2'b11, 2'd2, 8'h44, 2'd2, 8'h55, 1'b1, 2'd3, 16'hC3B2);
    chk("R10 load wins", 32'(arch_state[2*VW +: VW]), 32'hE7);
    chk("R9 odd half with pair_reg lsb set", 32'(arch_state[3*VW +: VW]), 32'hC3);
    chk_arch("R10 state");
    // lanes over pair; higher lane wins
    do_commit(2'b11, 2'd1, 8'h66, 2'd0, 8'h77, 1'b1, 2'd0, 16'h9988);
    chk("R10 lane1 over pair", 32'(arch_state[0 +: VW]), 32'h77);
    chk("R10 lane0 over pair", 32'(arch_state[VW +: VW]), 32'h66);
    do_commit(2'b11, 2'd0, 8'h12, 2'd0, 8'h34, 1'b0, 2'd0, 16'h0);
    chk("R10 higher lane wins", 32'(arch_state[0 +: VW]), 32'h34);
    chk_arch("R10 final state");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule